// File: doc/BRIEF.md
# Low-Power Entry and Wakeup Sequencer

This block steps a system out of normal operation into a low-power state and brings it back. Software arms an entry by pulsing a hint input, which sets an internal hint flag. The sequencer then confirms that the processor still reports sleeping. Next it confirms that the lifecycle controller, the non-volatile-memory controller and the flash controller all report idle. If either check fails, the entry is cancelled and the sequencer returns to the running state, emitting a one-cycle status pulse.

When the checks succeed, the sequencer enters its low-power state. There the IP clock enable drops, and each peripheral clock enable follows its own keep bit. The block waits for an enabled wakeup or a pending reset request. Either event starts a reset phase of fixed length. During that phase a reset request is driven together with a cause code, the IP clock stays off, and the other clock enables are restored. The sequencer then returns to the running state with the hint cleared.

Reset requests are latched as soon as they arrive and are serviced in arrival order against wakeups. The configuration write-enable output reports when the sequencer is idle in its running state.

Top module: `lp_seq`

## Requirements
- R1: After reset the sequencer is running. In that state: cfg_wen_o=1, ip_clk_en_o=1, every periph_clk_en_o bit is 1, usb_clk_en_o=1 (with usb_act_off_i=0), rst_req_o=0, rst_cause_o=0, hint_o=0, fall_thru_o=0 and abort_o=0.
- R2: A one-cycle pulse on lp_hint_set_i sets hint_o on the next clock edge. With the hint set, the sequencer leaves the running state on the following edge, and cfg_wen_o drops.
- R3: The cycle after leaving the running state is the sleep check. If cpu_sleep_i is 0 at the edge that ends this check, the sequencer returns to the running state. On that same edge fall_thru_o pulses for exactly one cycle and hint_o clears.
- R4: The cycle after a passed sleep check is the idle check. If at its closing edge cpu_sleep_i is 0, or any of lc_idle_i, nvm_idle_i or flash_idle_i is 0, the sequencer returns to the running state. On that edge abort_o pulses for one cycle and hint_o clears.
- R5: In the low-power state: ip_clk_en_o=0; periph_clk_en_o[i] equals pclk_keep_i[i]; usb_clk_en_o equals usb_lp_keep_i; cfg_wen_o=0; rst_req_o=0.
- R6: Outside the low-power state, usb_clk_en_o equals the inverse of usb_act_off_i.
- R7: cfg_wen_o is 1 only while the sequencer is in its running state, and never while rst_req_o or low power is active.
- R8: wake_i is acted on only in the low-power state. Asserting it in any other state leaves the state and the outputs unchanged, and it is not remembered.
- R9: A wakeup in low power drives rst_req_o=1 with rst_cause_o=1 (wake) for RST_CYC cycles, starting the edge after wake_i is sampled. ip_clk_en_o=0 throughout. The sequencer then returns to the running state with hint_o=0.
- R10: A rst_req_i pulse in the running state is latched on the first edge. On the second edge it starts a RST_CYC-cycle reset phase with rst_cause_o=2 (hardware request).
- R11: Events are serialized. A reset request latched before wake_i is served first with cause 2, and the wakeup is discarded. A reset request arriving in the same cycle as wake_i is served after the wake reset phase, as a second phase with cause 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| lp_hint_set_i | input | 1 | Software pulse that arms low-power entry |
| cpu_sleep_i | input | 1 | Processor reports sleeping |
| lc_idle_i | input | 1 | Lifecycle controller idle |
| nvm_idle_i | input | 1 | Non-volatile-memory controller idle |
| flash_idle_i | input | 1 | Flash controller idle |
| wake_i | input | 1 | Enabled wakeup indication |
| rst_req_i | input | 1 | Incoming reset request pulse |
| pclk_keep_i | input | N_PCLK | Per-peripheral keep-on bits for low power |
| usb_lp_keep_i | input | 1 | Keep USB clock on in low power |
| usb_act_off_i | input | 1 | Turn USB clock off while running |
| periph_clk_en_o | output | N_PCLK | Peripheral clock enables |
| usb_clk_en_o | output | 1 | USB clock enable |
| ip_clk_en_o | output | 1 | IP clock enable |
| rst_req_o | output | 1 | Reset request |
| rst_cause_o | output | 2 | Reset cause: 0 none, 1 wake, 2 hardware request |
| cfg_wen_o | output | 1 | Configuration write enable |
| hint_o | output | 1 | Current state of the low-power hint |
| fall_thru_o | output | 1 | One-cycle pulse: entry cancelled at the sleep check |
| abort_o | output | 1 | One-cycle pulse: entry cancelled at the idle check |

## Verification
Entry attempts are driven with several combinations of sleep and idle inputs. A sleep drop before the hint is consumed shows up as a fall-through pulse. A sleep drop after that point, or a single missing idle input (each one tried in turn), shows up as an abort pulse. Successful entries use varied keep patterns, which confirms that the low-power clock enables follow each bit individually and that wake causes a cause-1 reset phase. Separate directed runs show three things. A wake outside low power does nothing. A running-state reset request yields cause 2. A reset request latched before a wake, and one arriving together with a wake, are served in opposite orders.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_ENTRY    = 3'd1,
    ST_IDLE_CHK = 3'd2,
    ST_LOWPWR   = 3'd3,
    ST_RESET    = 3'd4
  } lp_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_WAKE  = 2'd1,
    CAUSE_HWREQ = 2'd2
  } rst_cause_e;

endpackage

// File: rtl/lp_evt_arb.sv
// Latches reset requests and orders them against wakeups.
module lp_evt_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_active_i,
  input  logic in_lp_i,
  input  logic wake_i,
  input  logic rst_req_i,
  output logic take_hw_o,
  output logic take_wake_o
);

  logic pend_q, pend_d;

  // a request latched in an earlier cycle wins over a wake seen now
  always_comb begin
    take_hw_o   = pend_q & (in_active_i | in_lp_i);
    take_wake_o = in_lp_i & wake_i & ~pend_q;
    pend_d      = rst_req_i | (pend_q & ~take_hw_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

endmodule

// File: rtl/lp_clk_ctl.sv
// Clock enable generation from sequencer state and control bits.
module lp_clk_ctl #(
  parameter int N_PCLK = 3
) (
  input  logic              in_lp_i,
  input  logic              in_run_i,
  input  logic [N_PCLK-1:0] pclk_keep_i,
  input  logic              usb_lp_keep_i,
  input  logic              usb_act_off_i,
  output logic [N_PCLK-1:0] periph_clk_en_o,
  output logic              usb_clk_en_o,
  output logic              ip_clk_en_o
);

  for (genvar g = 0; g < N_PCLK; g++) begin : g_pclk
    assign periph_clk_en_o[g] = in_lp_i ? pclk_keep_i[g] : 1'b1;
  end

  assign usb_clk_en_o = in_lp_i ? usb_lp_keep_i : ~usb_act_off_i;
  assign ip_clk_en_o  = in_run_i;

endmodule

// File: rtl/lp_seq_fsm.sv
// Entry / low-power / reset-phase control state machine.
module lp_seq_fsm
  import lp_seq_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hint_set_i,
  input  logic       cpu_sleep_i,
  input  logic       idle_all_i,
  input  logic       take_hw_i,
  input  logic       take_wake_i,
  output lp_state_e  state_o,
  output rst_cause_e cause_o,
  output logic       hint_o,
  output logic       fall_thru_o,
  output logic       abort_o
);

  localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYC - 1);

  lp_state_e        state_q, state_d;
  rst_cause_e       cause_q, cause_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             hint_q, hint_d, hint_clr;
  logic             fall_q, fall_d, abort_q, abort_d;

  always_comb begin
    state_d  = state_q;
    cause_d  = cause_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    hint_clr = 1'b0;
    fall_d   = 1'b0;
    abort_d  = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (take_hw_i) begin
          state_d = ST_RESET;
          cause_d = CAUSE_HWREQ;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end else if (hint_q) begin
          state_d = ST_ENTRY;
        end
      end
      ST_ENTRY: begin
        if (!cpu_sleep_i) begin
          state_d  = ST_ACTIVE;
          fall_d   = 1'b1;
          hint_clr = 1'b1;
        end else begin
          state_d = ST_IDLE_CHK;
        end
      end
      ST_IDLE_CHK: begin
        if (!cpu_sleep_i || !idle_all_i) begin
          state_d  = ST_ACTIVE;
          abort_d  = 1'b1;
          hint_clr = 1'b1;
        end else begin
          state_d = ST_LOWPWR;
        end
      end
      ST_LOWPWR: begin
        if (take_hw_i || take_wake_i) begin
          state_d = ST_RESET;
          cause_d = take_hw_i ? CAUSE_HWREQ : CAUSE_WAKE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_RESET: begin
        if (cnt_q == CNT_LAST) begin
          state_d  = ST_ACTIVE;
          cause_d  = CAUSE_NONE;
          hint_clr = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_ACTIVE;
        cause_d = CAUSE_NONE;
      end
    endcase
    hint_d = hint_clr ? 1'b0 : (hint_set_i | hint_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      cause_q <= CAUSE_NONE;
      hint_q  <= 1'b0;
      fall_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      hint_q  <= hint_d;
      fall_q  <= fall_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o     = state_q;
  assign cause_o     = cause_q;
  assign hint_o      = hint_q;
  assign fall_thru_o = fall_q;
  assign abort_o     = abort_q;

endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_seq_pkg::*;
#(
  parameter int N_PCLK  = 3,
  parameter int RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lp_hint_set_i,
  input  logic              cpu_sleep_i,
  input  logic              lc_idle_i,
  input  logic              nvm_idle_i,
  input  logic              flash_idle_i,
  input  logic              wake_i,
  input  logic              rst_req_i,
  input  logic [N_PCLK-1:0] pclk_keep_i,
  input  logic              usb_lp_keep_i,
  input  logic              usb_act_off_i,
  output logic [N_PCLK-1:0] periph_clk_en_o,
  output logic              usb_clk_en_o,
  output logic              ip_clk_en_o,
  output logic              rst_req_o,
  output logic [1:0]        rst_cause_o,
  output logic              cfg_wen_o,
  output logic              hint_o,
  output logic              fall_thru_o,
  output logic              abort_o
);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  lp_state_e  state;
  rst_cause_e cause;
  logic       take_hw, take_wake;
  logic       in_active, in_lp, in_run;

  assign in_active = (state == ST_ACTIVE);
  assign in_lp     = (state == ST_LOWPWR);
  assign in_run    = in_active || (state == ST_ENTRY) || (state == ST_IDLE_CHK);

  lp_evt_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_s2_q),
    .in_active_i (in_active),
    .in_lp_i     (in_lp),
    .wake_i      (wake_i),
    .rst_req_i   (rst_req_i),
    .take_hw_o   (take_hw),
    .take_wake_o (take_wake)
  );

  lp_seq_fsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_s2_q),
    .hint_set_i  (lp_hint_set_i),
    .cpu_sleep_i (cpu_sleep_i),
    .idle_all_i  (lc_idle_i & nvm_idle_i & flash_idle_i),
    .take_hw_i   (take_hw),
    .take_wake_i (take_wake),
    .state_o     (state),
    .cause_o     (cause),
    .hint_o      (hint_o),
    .fall_thru_o (fall_thru_o),
    .abort_o     (abort_o)
  );

  lp_clk_ctl #(.N_PCLK(N_PCLK)) u_clk (
    .in_lp_i         (in_lp),
    .in_run_i        (in_run),
    .pclk_keep_i     (pclk_keep_i),
    .usb_lp_keep_i   (usb_lp_keep_i),
    .usb_act_off_i   (usb_act_off_i),
    .periph_clk_en_o (periph_clk_en_o),
    .usb_clk_en_o    (usb_clk_en_o),
    .ip_clk_en_o     (ip_clk_en_o)
  );

  assign rst_req_o   = (state == ST_RESET);
  assign rst_cause_o = cause;
  assign cfg_wen_o   = in_active;

endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ip_clk_en_o,
  input logic       rst_req_o,
  input logic [1:0] rst_cause_o,
  input logic       cfg_wen_o,
  input logic       hint_o,
  input logic       fall_thru_o,
  input logic       abort_o
);

  a_r3_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_thru_o |=> !fall_thru_o);

  a_r4_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  a_r3_fall_clears_hint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_thru_o || abort_o) |-> (!hint_o && cfg_wen_o && !(fall_thru_o && abort_o)));

  a_r7_cfg_only_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wen_o |-> (ip_clk_en_o && !rst_req_o));

  a_r9_ip_off_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (!ip_clk_en_o && rst_cause_o != 2'd0));

  a_r9_cause_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && $past(rst_req_o)) |-> $stable(rst_cause_o));

  a_r5_lp_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ip_clk_en_o |-> !cfg_wen_o);

endmodule

bind lp_seq lp_seq_chk u_chk (.*);

// File: tb/lp_seq_test.sv
module lp_seq_test;

  localparam int NP = 3;
  localparam int RC = 4;

  logic clk = 1'b0;
  logic rst_ni;
  logic hint_set, cpu_sleep, lc_idle, nvm_idle, flash_idle, wake, rreq;
  logic [NP-1:0] keep;
  logic ukeep, uoff;
  logic [NP-1:0] pclk_en;
  logic usb_en, ip_en, rst_req, cfg_wen, hint, fall, abrt;
  logic [1:0] cause;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lp_seq #(.N_PCLK(NP), .RST_CYC(RC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .lp_hint_set_i(hint_set),
    .cpu_sleep_i(cpu_sleep), .lc_idle_i(lc_idle), .nvm_idle_i(nvm_idle),
    .flash_idle_i(flash_idle), .wake_i(wake), .rst_req_i(rreq),
    .pclk_keep_i(keep), .usb_lp_keep_i(ukeep), .usb_act_off_i(uoff),
    .periph_clk_en_o(pclk_en), .usb_clk_en_o(usb_en), .ip_clk_en_o(ip_en),
    .rst_req_o(rst_req), .rst_cause_o(cause), .cfg_wen_o(cfg_wen),
    .hint_o(hint), .fall_thru_o(fall), .abort_o(abrt)
  );

  // vector: {keep[2:0], usb_lp_keep, sleep_at_entry, sleep_at_check, lc, nvm, flash}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    9'b101_1_1_1_111,
    9'b000_0_1_1_111,
    9'b111_1_0_0_111,
    9'b010_0_1_0_111,
    9'b000_0_1_1_011,
    9'b000_0_1_1_101,
    9'b000_0_1_1_110,
    9'b110_0_1_1_111
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // hint pulse followed by three edges: ends in low power when all checks pass
  task automatic arm_lp();
    hint_set = 1'b1; tick(); hint_set = 1'b0;
    tick(); tick(); tick();
  endtask

  task automatic wait_reset_phase();
    for (int k = 0; k < RC; k++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_ni = 1'b0; hint_set = 1'b0; cpu_sleep = 1'b1; lc_idle = 1'b1;
    nvm_idle = 1'b1; flash_idle = 1'b1; wake = 1'b0; rreq = 1'b0;
    keep = '0; ukeep = 1'b0; uoff = 1'b0;
    tick(); tick(); tick();
    rst_ni = 1'b1;
    tick(); tick(); tick(); tick();

    // R1 reset state
    chk("R1", "cfg_wen", 8'(cfg_wen), 8'd1);
    chk("R1", "ip_en", 8'(ip_en), 8'd1);
    chk("R1", "pclk_en", 8'(pclk_en), 8'h7);
    chk("R1", "usb_en", 8'(usb_en), 8'd1);
    chk("R1", "rst_req", 8'(rst_req), 8'd0);
    chk("R1", "cause", 8'(cause), 8'd0);
    chk("R1", "hint/fall/abort", {5'd0, hint, fall, abrt}, 8'd0);

    // table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      logic [8:0] w;
      logic s1, s2;
      w = VEC[v];
      s1 = w[4]; s2 = w[3];
      keep = w[8:6]; ukeep = w[5];
      lc_idle = w[2]; nvm_idle = w[1]; flash_idle = w[0];
      cpu_sleep = s1;
      hint_set = 1'b1; tick(); hint_set = 1'b0;
      chk("R2", "hint set", 8'(hint), 8'd1);
      tick();
      chk("R2", "left running", 8'(cfg_wen), 8'd0);
      tick();
      if (!s1) begin
        chk("R3", "fall pulse", 8'(fall), 8'd1);
        chk("R3", "back running", 8'(cfg_wen), 8'd1);
        chk("R3", "hint clr", 8'(hint), 8'd0);
        tick();
        chk("R3", "fall one cycle", 8'(fall), 8'd0);
      end else begin
        cpu_sleep = s2;
        tick();
        if (!s2 || w[2:0] != 3'b111) begin
          chk("R4", "abort pulse", 8'(abrt), 8'd1);
          chk("R4", "back running", 8'(cfg_wen), 8'd1);
          chk("R4", "hint clr", 8'(hint), 8'd0);
          tick();
          chk("R4", "abort one cycle", 8'(abrt), 8'd0);
        end else begin
          chk("R5", "ip off", 8'(ip_en), 8'd0);
          chk("R5", "pclk keep", 8'(pclk_en), 8'(w[8:6]));
          chk("R5", "usb keep", 8'(usb_en), 8'(w[5]));
          chk("R5", "locked", {6'd0, cfg_wen, rst_req}, 8'd0);
          wake = 1'b1; tick(); wake = 1'b0;
          chk("R9", "rst_req", 8'(rst_req), 8'd1);
          chk("R9", "cause wake", 8'(cause), 8'd1);
          chk("R9", "ip off", 8'(ip_en), 8'd0);
          for (int k = 1; k < RC; k++) tick();
          chk("R9", "still reset last cycle", 8'(rst_req), 8'd1);
          tick();
          chk("R9", "back running", {6'd0, cfg_wen, rst_req}, 8'h2);
          chk("R9", "hint clr", 8'(hint), 8'd0);
          chk("R9", "clocks on", {4'd0, ip_en, pclk_en}, 8'hF);
        end
      end
      cpu_sleep = 1'b1; lc_idle = 1'b1; nvm_idle = 1'b1; flash_idle = 1'b1;
      tick();
    end

    // R6 USB clock in running state
    uoff = 1'b1; #1;
    chk("R6", "usb off running", 8'(usb_en), 8'd0);
    uoff = 1'b0; #1;
    chk("R6", "usb on running", 8'(usb_en), 8'd1);

    // R8 wake outside low power ignored, not remembered
    wake = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", "no effect running", {6'd0, cfg_wen, rst_req}, 8'h2);
    end
    wake = 1'b0;
    keep = 3'b011;
    arm_lp();
    tick(); tick();
    chk("R8", "stays in low power", {6'd0, cfg_wen, rst_req}, 8'h0);
    chk("R5", "pclk keep directed", 8'(pclk_en), 8'h3);
    wake = 1'b1; tick(); wake = 1'b0;
    wait_reset_phase();
    chk("R8", "exit after wake", 8'(cfg_wen), 8'd1);

    // R10 reset request while running
    rreq = 1'b1; tick(); rreq = 1'b0;
    chk("R10", "latched only", {6'd0, cfg_wen, rst_req}, 8'h2);
    tick();
    chk("R10", "rst_req", 8'(rst_req), 8'd1);
    chk("R10", "cause hw", 8'(cause), 8'd2);
    for (int k = 1; k < RC; k++) tick();
    tick();
    chk("R10", "back running", {6'd0, cfg_wen, rst_req}, 8'h2);

    // R11 reset latched before wake is served first, wake discarded
    arm_lp();
    rreq = 1'b1; tick(); rreq = 1'b0;
    chk("R11", "still low power", {6'd0, cfg_wen, rst_req}, 8'h0);
    wake = 1'b1; tick(); wake = 1'b0;
    chk("R11", "earlier reset first", 8'(cause), 8'd2);
    for (int k = 1; k < RC; k++) tick();
    tick();
    chk("R11", "running after hw", {6'd0, cfg_wen, rst_req}, 8'h2);
    tick();
    chk("R11", "wake discarded", {6'd0, cfg_wen, rst_req}, 8'h2);

    // R11 coincident wake and reset: wake then hw
    arm_lp();
    rreq = 1'b1; wake = 1'b1; tick(); rreq = 1'b0; wake = 1'b0;
    chk("R11", "coincident wake first", 8'(cause), 8'd1);
    for (int k = 1; k < RC; k++) tick();
    tick();
    chk("R11", "running between", {6'd0, cfg_wen, rst_req}, 8'h2);
    tick();
    chk("R11", "second phase rst", 8'(rst_req), 8'd1);
    chk("R11", "second phase cause", 8'(cause), 8'd2);
    wait_reset_phase();
    chk("R11", "final running", {6'd0, cfg_wen, rst_req}, 8'h2);

    summary();
  end

endmodule